// File: doc/BRIEF.md
# Host mailbox command sequencer

This engine carries one command block from a local dword buffer to a management controller over a shared mailbox window, then optionally brings the controller's reply back into the same buffer. A host pulses `start` with a byte length, a timeout in milliseconds and a reply flag. The engine validates the length and then owns a semaphore bit shared with the firmware. It copies the command into the mailbox with a read-back after every write, rings a doorbell and waits for the firmware-ready flag. It then unpacks a reply whose size comes from the reply header, and always hands the semaphore back before it reports completion.

All register traffic goes out on one master port with a valid/ready handshake. A request (`m_valid` with address, write flag and write data) stays unchanged until the slave accepts it with `m_ready`. A read returns `m_rdata` in the accepting cycle. The slave may hold `m_ready` low for as long as it likes, and the engine simply waits. The local buffer is a plain memory port: `buf_rdata` reflects `buf_addr` in the same cycle, and `buf_we` writes `buf_wdata` at the clock edge. Wait intervals are expressed in clock cycles by parameters (`SEM_POLL_CYC` for the semaphore interval, `MS_CYC` for one millisecond, `SEM_MAX_READS` for the semaphore give-up point).

Top module: `mbx_cmd_seq`

## Requirements
- R1: A start with `byte_len` equal to 0, above 256, or with `byte_len[1:0]` nonzero finishes with `err` = 1 and issues no register transaction at all.
- R2: The engine reads the sync register at `SEM_ADDR`. When bit 2 of the value reads 0, it writes back the value it read with bit 2 set. No mailbox or control-register access happens unless the engine holds that bit.
- R3: While bit 2 of the sync register reads 1, the engine reads it again after `SEM_POLL_CYC` cycles. After `SEM_MAX_READS` reads that all see it set, it finishes with `err` = 2 and never writes the sync register.
- R4: Command dword i from buffer entry i is written to `MBOX_BASE` + 4·i for i = 0 up to `byte_len`/4 − 1 in rising order. Each write is followed at once by a read of the same address.
- R5: After the last command dword, the engine reads the control register at `CTL_ADDR` and writes back the value it read with bit 0 set (doorbell).
- R6: The engine then reads the control register until bit 2 reads 1. It makes one read at once and another after each wait of `MS_CYC` cycles, with at most `timeout_ms` + 1 reads in total. If none of them sees bit 2 set, it finishes with `err` = 3.
- R7: With `want_reply` = 0, the engine makes no mailbox read after the doorbell. With `want_reply` = 1, it reads the header dword at `MBOX_BASE` into buffer entry 0 and takes the reply length L from header bits 15:8. When L = 0, it finishes with `err` = 0.
- R8: If `byte_len` < L + 4, the engine finishes with `err` = 4. Otherwise it copies mailbox dwords 1 up to (L + 3) >> 2 into the buffer entries with the same index, and no others.
- R9: Every run that acquired the semaphore ends by reading the sync register and writing back the value it read with only bit 2 cleared, whatever the result. A success reports `err` = 0.
- R10: One command runs at a time. `start` is ignored while `busy` or `done` is high. `done` is a one-cycle pulse, and `err` keeps its value from that pulse until the next accepted start.
- R11: A register request that is not yet accepted keeps `m_valid`, `m_write`, `m_addr` and `m_wdata` unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (one-cycle pulse) |
| byte_len | input | LEN_W | Command buffer length in bytes |
| timeout_ms | input | TMO_W | Firmware-ready wait limit in milliseconds |
| want_reply | input | 1 | Collect the reply into the buffer |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 3 | 0 ok, 1 bad length, 2 semaphore timeout, 3 firmware timeout, 4 reply too large |
| buf_addr | output | BUF_AW | Local buffer dword index |
| buf_rdata | input | 32 | Buffer read data for `buf_addr` |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | 32 | Buffer write data |
| m_valid | output | 1 | Register request valid |
| m_write | output | 1 | 1 write, 0 read |
| m_addr | output | ADDR_W | Register byte address |
| m_wdata | output | 32 | Register write data |
| m_ready | input | 1 | Slave accepts the request |
| m_rdata | input | 32 | Read data, valid when a read is accepted |

## Verification
The bench attacks the length edges (0, 6, 260) and expects a design that skipped a check to grab the semaphore or write the mailbox. It holds the semaphore busy for a few reads and then forever. A wrong poll limit shows up as a different read count, and a bad timeout path shows up as a stray sync write. It starves the firmware-ready flag with `timeout_ms` of 3 and of 0 to catch off-by-one poll counts. It also checks that the sync value always returns to its original pattern, which a design that forgot the release on an error path, or cleared other bits, would break. On replies it uses lengths of 0, 9, 12 (exact fit) and 13 (one byte too many) and checks that the entry past the reply is untouched. An off-by-one in the last index would either leave data behind or overwrite that entry.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned DW        = 32;
  localparam int unsigned SEM_BIT   = 2;
  localparam int unsigned SWRDY_BIT = 0;
  localparam int unsigned FWRDY_BIT = 2;

  localparam logic [DW-1:0] SEM_MASK   = 32'h1 << SEM_BIT;
  localparam logic [DW-1:0] SWRDY_MASK = 32'h1 << SWRDY_BIT;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_BADLEN = 3'd1,
    ERR_SEMTO  = 3'd2,
    ERR_FWTO   = 3'd3,
    ERR_NOROOM = 3'd4
  } mbx_err_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SEM_RD, ST_SEM_WAIT, ST_SEM_WR,
    ST_CMD_WR, ST_CMD_RB, ST_CTL_RD, ST_CTL_WR,
    ST_FW_RD, ST_FW_WAIT, ST_HDR_RD, ST_DAT_RD,
    ST_REL_RD, ST_REL_WR, ST_DONE
  } mbx_state_e;

endpackage

// File: rtl/mbx_len_check.sv
module mbx_len_check #(
  parameter int MAX_BYTES = 256,
  parameter int LEN_W     = $clog2(MAX_BYTES) + 1
) (
  input  logic [LEN_W-1:0] byte_len,
  output logic             len_ok
);
  // Nonzero, within the window, whole dwords only.
  always_comb begin
    len_ok = (byte_len != '0) &&
             (int'(byte_len) <= MAX_BYTES) &&
             (byte_len[1:0] == 2'b00);
  end
endmodule

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
  parameter int INTERVAL = 4,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             arm,
  input  logic [CNT_W-1:0] limit,
  output logic             wait_done,
  output logic             last
);
  localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [IW-1:0]    ival;
  logic             running;
  logic [CNT_W-1:0] waits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ival    <= '0;
      running <= 1'b0;
      waits   <= '0;
    end else if (clear) begin
      running <= 1'b0;
      waits   <= '0;
    end else if (arm) begin
      running <= 1'b1;
      ival    <= IW'(INTERVAL - 1);
      waits   <= waits + 1'b1;
    end else if (running) begin
      if (ival == '0) running <= 1'b0;
      else            ival    <= ival - 1'b1;
    end
  end

  assign wait_done = running && (ival == '0);
  assign last      = (waits == limit);
endmodule

// File: rtl/mbx_cmd_seq.sv
module mbx_cmd_seq
  import mbx_pkg::*;
#(
  parameter int MAX_BYTES     = 256,
  parameter int LEN_W         = $clog2(MAX_BYTES) + 1,
  parameter int BUF_AW        = $clog2(MAX_BYTES / 4),
  parameter int TMO_W         = 16,
  parameter int ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] SEM_ADDR  = 16'h0100,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 16'h0104,
  parameter logic [ADDR_W-1:0] MBOX_BASE = 16'h0200,
  parameter int SEM_POLL_CYC  = 250,
  parameter int SEM_MAX_READS = 400000,
  parameter int MS_CYC        = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  byte_len,
  input  logic [TMO_W-1:0]  timeout_ms,
  input  logic              want_reply,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err,
  output logic [BUF_AW-1:0] buf_addr,
  input  logic [31:0]       buf_rdata,
  output logic              buf_we,
  output logic [31:0]       buf_wdata,
  output logic              m_valid,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [31:0]       m_wdata,
  input  logic              m_ready,
  input  logic [31:0]       m_rdata
);
  localparam int SEM_CW = $clog2(SEM_MAX_READS);

  mbx_state_e        state;
  mbx_err_e          err_q;
  logic [LEN_W-1:0]  len_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              want_q;
  logic [BUF_AW-1:0] idx, last_rep, last_cmd;
  logic [31:0]       hold_q;
  logic              acc, len_ok;
  logic [7:0]        rep_len;
  logic              too_small;
  logic              sem_clear, sem_arm, sem_done, sem_last;
  logic              fw_clear, fw_arm, fw_done, fw_last;

  function automatic logic [ADDR_W-1:0] mb_at(input logic [BUF_AW-1:0] i);
    return MBOX_BASE + ADDR_W'({i, 2'b00});
  endfunction

  mbx_len_check #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_len (
    .byte_len (byte_len),
    .len_ok   (len_ok)
  );

  mbx_poll_timer #(.INTERVAL(SEM_POLL_CYC), .CNT_W(SEM_CW)) u_sem_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (sem_clear),
    .arm       (sem_arm),
    .limit     (SEM_CW'(SEM_MAX_READS - 1)),
    .wait_done (sem_done),
    .last      (sem_last)
  );

  mbx_poll_timer #(.INTERVAL(MS_CYC), .CNT_W(TMO_W)) u_fw_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (fw_clear),
    .arm       (fw_arm),
    .limit     (tmo_q),
    .wait_done (fw_done),
    .last      (fw_last)
  );

  assign acc       = m_valid && m_ready;
  assign rep_len   = m_rdata[15:8];
  assign too_small = int'(len_q) < (int'(rep_len) + 4);
  assign last_cmd  = BUF_AW'(len_q[LEN_W-1:2] - 1'b1);

  assign sem_clear = (state == ST_IDLE);
  assign sem_arm   = (state == ST_SEM_RD) && acc && m_rdata[SEM_BIT] && !sem_last;
  assign fw_clear  = (state == ST_CTL_WR);
  assign fw_arm    = (state == ST_FW_RD) && acc && !m_rdata[FWRDY_BIT] && !fw_last;

  assign busy      = (state != ST_IDLE) && (state != ST_DONE);
  assign done      = (state == ST_DONE);
  assign err       = err_q;
  assign buf_addr  = idx;
  assign buf_wdata = m_rdata;
  assign buf_we    = acc && ((state == ST_HDR_RD) || (state == ST_DAT_RD));

  // Request generation: a pure function of state, so it holds until accepted.
  always_comb begin
    m_valid = 1'b0;
    m_write = 1'b0;
    m_addr  = SEM_ADDR;
    m_wdata = hold_q;
    unique case (state)
      ST_SEM_RD, ST_REL_RD: m_valid = 1'b1;
      ST_SEM_WR, ST_REL_WR: begin m_valid = 1'b1; m_write = 1'b1; end
      ST_CMD_WR: begin
        m_valid = 1'b1; m_write = 1'b1; m_addr = mb_at(idx); m_wdata = buf_rdata;
      end
      ST_CMD_RB, ST_HDR_RD, ST_DAT_RD: begin
        m_valid = 1'b1; m_addr = mb_at(idx);
      end
      ST_CTL_RD, ST_FW_RD: begin m_valid = 1'b1; m_addr = CTL_ADDR; end
      ST_CTL_WR: begin m_valid = 1'b1; m_write = 1'b1; m_addr = CTL_ADDR; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      err_q    <= ERR_NONE;
      len_q    <= '0;
      tmo_q    <= '0;
      want_q   <= 1'b0;
      idx      <= '0;
      last_rep <= '0;
      hold_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          len_q  <= byte_len;
          tmo_q  <= timeout_ms;
          want_q <= want_reply;
          idx    <= '0;
          if (len_ok) begin
            err_q <= ERR_NONE;
            state <= ST_SEM_RD;
          end else begin
            err_q <= ERR_BADLEN;
            state <= ST_DONE;
          end
        end
        ST_SEM_RD: if (acc) begin
          if (!m_rdata[SEM_BIT]) begin
            hold_q <= m_rdata | SEM_MASK;
            state  <= ST_SEM_WR;
          end else if (sem_last) begin
            err_q <= ERR_SEMTO;
            state <= ST_DONE;
          end else begin
            state <= ST_SEM_WAIT;
          end
        end
        ST_SEM_WAIT: if (sem_done) state <= ST_SEM_RD;
        ST_SEM_WR: if (acc) begin
          idx   <= '0;
          state <= ST_CMD_WR;
        end
        ST_CMD_WR: if (acc) state <= ST_CMD_RB;
        ST_CMD_RB: if (acc) begin
          if (idx == last_cmd) state <= ST_CTL_RD;
          else begin
            idx   <= idx + 1'b1;
            state <= ST_CMD_WR;
          end
        end
        ST_CTL_RD: if (acc) begin
          hold_q <= m_rdata | SWRDY_MASK;
          state  <= ST_CTL_WR;
        end
        ST_CTL_WR: if (acc) state <= ST_FW_RD;
        ST_FW_RD: if (acc) begin
          if (m_rdata[FWRDY_BIT]) begin
            idx   <= '0;
            state <= want_q ? ST_HDR_RD : ST_REL_RD;
          end else if (fw_last) begin
            err_q <= ERR_FWTO;
            state <= ST_REL_RD;
          end else begin
            state <= ST_FW_WAIT;
          end
        end
        ST_FW_WAIT: if (fw_done) state <= ST_FW_RD;
        ST_HDR_RD: if (acc) begin
          if (rep_len == 8'd0) begin
            state <= ST_REL_RD;
          end else if (too_small) begin
            err_q <= ERR_NOROOM;
            state <= ST_REL_RD;
          end else begin
            idx      <= BUF_AW'(1);
            last_rep <= BUF_AW'(({1'b0, rep_len} + 9'd3) >> 2);
            state    <= ST_DAT_RD;
          end
        end
        ST_DAT_RD: if (acc) begin
          if (idx == last_rep) state <= ST_REL_RD;
          else                 idx   <= idx + 1'b1;
        end
        ST_REL_RD: if (acc) begin
          hold_q <= m_rdata & ~SEM_MASK;
          state  <= ST_REL_WR;
        end
        ST_REL_WR: if (acc) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_cmd_seq_chk.sv
module mbx_cmd_seq_chk
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SEM_ADDR = 16'h0100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [2:0]        err,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_write,
  input logic [ADDR_W-1:0] m_addr,
  input logic [31:0]       m_wdata
);
  // Semaphore ownership as seen on the bus.
  logic sem_held;
  always_ff @(posedge clk) begin
    if (!rst_n) sem_held <= 1'b0;
    else if (m_valid && m_ready && m_write && (m_addr == SEM_ADDR))
      sem_held <= m_wdata[SEM_BIT];
  end

  p_mbox_needs_sem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && (m_addr != SEM_ADDR)) |-> sem_held);

  p_released_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sem_held);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=>
      (m_valid && $stable(m_write) && $stable(m_addr) && $stable(m_wdata)));
endmodule

bind mbx_cmd_seq mbx_cmd_seq_chk #(.ADDR_W(ADDR_W), .SEM_ADDR(SEM_ADDR)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_write (m_write),
  .m_addr  (m_addr),
  .m_wdata (m_wdata)
);

// File: tb/mbx_cmd_seq_tb_top.sv
module mbx_cmd_seq_tb_top;
  localparam logic [15:0] SEM_A = 16'h0100;
  localparam logic [15:0] CTL_A = 16'h0104;
  localparam logic [15:0] MB_A  = 16'h0200;
  localparam int SEM_READS = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  byte_len = '0;
  logic [15:0] timeout_ms = '0;
  logic        want_reply = 1'b0;
  logic        busy, done;
  logic [2:0]  err;
  logic [5:0]  buf_addr;
  logic [31:0] buf_rdata;
  logic        buf_we;
  logic [31:0] buf_wdata;
  logic        m_valid, m_write, m_ready;
  logic [15:0] m_addr;
  logic [31:0] m_wdata;
  logic [31:0] m_rdata;

  always #10 clk = ~clk;

  mbx_cmd_seq #(
    .SEM_ADDR(SEM_A), .CTL_ADDR(CTL_A), .MBOX_BASE(MB_A),
    .SEM_POLL_CYC(4), .SEM_MAX_READS(SEM_READS), .MS_CYC(10)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_len(byte_len),
    .timeout_ms(timeout_ms), .want_reply(want_reply), .busy(busy), .done(done),
    .err(err), .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_we(buf_we),
    .buf_wdata(buf_wdata), .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata)
  );

  // ---------------- slave / firmware model ----------------
  logic [31:0] mbox [64];
  logic [31:0] cbuf [64];
  logic [31:0] reply_img [64];
  logic [31:0] sync_reg, ctl_reg, sync_set_val, door_val;
  int  cfg_sem_busy, cfg_fw_delay;
  bit  cfg_fw_never, cfg_reply, clr;
  int  sem_left, fw_cnt;
  bit  fw_pend, gate, prev_wr;
  logic [15:0] prev_addr;
  int  n_txn, n_sync_rd, n_sync_wr, n_ctl_rd, n_mb_wr, n_flush, n_mb_rd, n_done;

  logic        in_mb;
  logic [5:0]  sidx;
  assign in_mb     = (m_addr >= MB_A) && (m_addr < (MB_A + 16'h0100));
  assign sidx      = 6'((m_addr - MB_A) >> 2);
  assign m_ready   = m_valid && gate;
  assign buf_rdata = cbuf[buf_addr];

  always_comb begin
    if (m_addr == SEM_A)      m_rdata = sync_reg | ((sem_left != 0) ? 32'h4 : 32'h0);
    else if (m_addr == CTL_A) m_rdata = ctl_reg |
                                ((fw_pend && fw_cnt == 0 && !cfg_fw_never) ? 32'h4 : 32'h0);
    else if (in_mb)           m_rdata = mbox[sidx];
    else                      m_rdata = 32'h0;
  end

  always @(posedge clk) begin
    gate <= ~gate;
    if (done) n_done <= n_done + 1;
    if (buf_we) cbuf[buf_addr] <= buf_wdata;
    if (clr) begin
      sync_reg <= 32'h11; ctl_reg <= 32'h30; sync_set_val <= '0; door_val <= '0;
      sem_left <= cfg_sem_busy; fw_pend <= 1'b0; fw_cnt <= 0; prev_wr <= 1'b0;
      prev_addr <= '0; n_txn <= 0; n_sync_rd <= 0; n_sync_wr <= 0; n_ctl_rd <= 0;
      n_mb_wr <= 0; n_flush <= 0; n_mb_rd <= 0; n_done <= 0;
      for (int k = 0; k < 64; k++) begin
        mbox[k] <= 32'h0;
        cbuf[k] <= 32'hDEAD0000 + 32'(k);
      end
    end else if (m_valid && m_ready) begin
      n_txn     <= n_txn + 1;
      prev_wr   <= m_write;
      prev_addr <= m_addr;
      if (m_write) begin
        if (m_addr == SEM_A) begin
          sync_reg  <= m_wdata;
          n_sync_wr <= n_sync_wr + 1;
          if (m_wdata[2]) sync_set_val <= m_wdata;
        end else if (m_addr == CTL_A) begin
          ctl_reg  <= m_wdata & ~32'h4;
          door_val <= m_wdata;
          if (m_wdata[0]) begin
            fw_pend <= 1'b1;
            fw_cnt  <= cfg_fw_delay;
            if (cfg_reply) for (int k = 0; k < 64; k++) mbox[k] <= reply_img[k];
          end
        end else if (in_mb) begin
          mbox[sidx] <= m_wdata;
          n_mb_wr    <= n_mb_wr + 1;
        end
      end else begin
        if (m_addr == SEM_A) begin
          n_sync_rd <= n_sync_rd + 1;
          if (sem_left > 0) sem_left <= sem_left - 1;
        end else if (m_addr == CTL_A) begin
          n_ctl_rd <= n_ctl_rd + 1;
          if (fw_pend && fw_cnt > 0) fw_cnt <= fw_cnt - 1;
        end else if (in_mb) begin
          if (prev_wr && prev_addr == m_addr) n_flush <= n_flush + 1;
          else                                 n_mb_rd <= n_mb_rd + 1;
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setup(input int sem_busy, input int fw_delay, input bit never, input bit rep);
    cfg_sem_busy = sem_busy; cfg_fw_delay = fw_delay;
    cfg_fw_never = never;    cfg_reply    = rep;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic run_cmd(input logic [8:0] len, input logic [15:0] tmo, input bit want,
                         input bit poke, output logic [2:0] e_out);
    int w;
    @(negedge clk);
    start = 1'b1; byte_len = len; timeout_ms = tmo; want_reply = want;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; byte_len = 9'd0;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (done !== 1'b1 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    if (w >= 5000) chk("R10 done never seen", 32'(done), 32'h1);
    e_out = err;
    @(negedge clk);
    chk("R10 done lasts one cycle", 32'(done), 32'h0);
    chk("R10 err held after done", 32'(err), 32'(e_out));
  endtask

  // ---------------- directed scenarios ----------------
  task automatic t_reset();
    chk("R10 reset busy", 32'(busy), 32'h0);
    chk("R10 reset done", 32'(done), 32'h0);
    chk("R10 reset err", 32'(err), 32'h0);
    chk("R11 reset m_valid", 32'(m_valid), 32'h0);
  endtask

  task automatic t_badlen();
    logic [2:0] e;
    setup(0, 0, 1'b0, 1'b0);
    run_cmd(9'd0, 16'd5, 1'b0, 1'b0, e);
    chk("R1 len 0 err", 32'(e), 32'h1);
    run_cmd(9'd260, 16'd5, 1'b0, 1'b0, e);
    chk("R1 len 260 err", 32'(e), 32'h1);
    run_cmd(9'd6, 16'd5, 1'b0, 1'b0, e);
    chk("R1 len 6 err", 32'(e), 32'h1);
    chk("R1 no bus traffic", 32'(n_txn), 32'h0);
  endtask

  task automatic t_basic();
    logic [2:0] e;
    setup(0, 2, 1'b0, 1'b0);
    run_cmd(9'd12, 16'd5, 1'b0, 1'b0, e);
    chk("R9 success err", 32'(e), 32'h0);
    for (int k = 0; k < 3; k++)
      chk("R4 mailbox dword", mbox[k], 32'hDEAD0000 + 32'(k));
    chk("R4 mailbox write count", 32'(n_mb_wr), 32'd3);
    chk("R4 flush read-backs", 32'(n_flush), 32'd3);
    chk("R2 semaphore set value", sync_set_val, 32'h15);
    chk("R5 doorbell value", door_val, 32'h31);
    chk("R6 control reads", 32'(n_ctl_rd), 32'd4);
    chk("R7 no reply reads", 32'(n_mb_rd), 32'd0);
    chk("R9 semaphore released", sync_reg, 32'h11);
  endtask

  task automatic t_sem_wait();
    logic [2:0] e;
    setup(3, 0, 1'b0, 1'b0);
    run_cmd(9'd4, 16'd5, 1'b0, 1'b0, e);
    chk("R3 busy semaphore then ok", 32'(e), 32'h0);
    chk("R3 sync reads", 32'(n_sync_rd), 32'd5);
  endtask

  task automatic t_sem_timeout();
    logic [2:0] e;
    setup(-1, 0, 1'b0, 1'b0);
    run_cmd(9'd8, 16'd5, 1'b0, 1'b0, e);
    chk("R3 semaphore timeout err", 32'(e), 32'h2);
    chk("R3 sync reads at give-up", 32'(n_sync_rd), 32'(SEM_READS));
    chk("R3 no sync write", 32'(n_sync_wr), 32'd0);
    chk("R2 no mailbox write", 32'(n_mb_wr), 32'd0);
  endtask

  task automatic t_fw_timeout(input logic [15:0] tmo);
    logic [2:0] e;
    setup(0, 0, 1'b1, 1'b0);
    run_cmd(9'd8, tmo, 1'b1, 1'b0, e);
    chk("R6 firmware timeout err", 32'(e), 32'h3);
    chk("R6 control reads", 32'(n_ctl_rd), 32'(tmo) + 32'd2);
    chk("R9 released after timeout", sync_reg, 32'h11);
    chk("R9 sync writes", 32'(n_sync_wr), 32'd2);
  endtask

  task automatic t_reply(input logic [8:0] len, input logic [7:0] rlen,
                         input logic [2:0] exp_err, input int exp_rd);
    logic [2:0] e;
    for (int k = 0; k < 64; k++) reply_img[k] = 32'hC0DE0000 + 32'(k);
    reply_img[0] = {8'h77, 8'h00, rlen, 8'h31};
    setup(0, 1, 1'b0, 1'b1);
    run_cmd(len, 16'd5, 1'b1, 1'b0, e);
    chk("R8 reply result err", 32'(e), 32'(exp_err));
    chk("R7 header stored", cbuf[0], reply_img[0]);
    chk("R8 mailbox reads", 32'(n_mb_rd), 32'(exp_rd));
    for (int k = 1; k < 6; k++)
      chk("R8 buffer entry", cbuf[k], (k < exp_rd) ? reply_img[k] : 32'hDEAD0000 + 32'(k));
    chk("R9 released after reply", sync_reg, 32'h11);
  endtask

  task automatic t_busy_start();
    logic [2:0] e;
    setup(0, 3, 1'b0, 1'b0);
    run_cmd(9'd16, 16'd5, 1'b0, 1'b1, e);
    repeat (20) @(negedge clk);
    chk("R10 start while busy ignored", 32'(e), 32'h0);
    chk("R10 single done pulse", 32'(n_done), 32'd1);
    chk("R10 idle after run", 32'(busy), 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: run hung");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_badlen();
    t_basic();
    t_sem_wait();
    t_sem_timeout();
    t_fw_timeout(16'd3);
    t_fw_timeout(16'd0);
    t_reply(9'd16, 8'd0,  3'd0, 1);   // R7 zero-length reply
    t_reply(9'd20, 8'd9,  3'd0, 4);   // R8 odd length, entries 1..3
    t_reply(9'd16, 8'd12, 3'd0, 4);   // R8 exact fit
    t_reply(9'd16, 8'd13, 3'd4, 1);   // R8 one byte too many
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule